// File: doc/BRIEF.md
# Single-Wire Bus Master Register Bank

This block is the software-facing half of a single-wire bus master. It is a 32-bit AXI4-Lite slave that holds the instruction, control and interrupt-mask words for a separate slot-timing engine. It presents those fields to the engine as plain signals. Every clock it captures the engine's ready, done and presence flags and its received byte, so software can read them back.

A level-sensitive interrupt is raised from the captured ready and done flags, and each flag has its own mask bit. A mode bit in the instruction word decides who owns the open-drain bus pin. In engine mode the timing engine pulls the pin low. In GPIO mode software either drives the pin to a chosen level or releases it to read it. The pin level is always synchronised through two flops. The synchronised level is shown in a GPIO data register and passed on to the engine.

Top module: `owb_regbank`

## Requirements
- R1: After reset, the words at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero. Offset 0x18 reads 0x7600_0100 and offset 0x1C reads 0x10EE_4453. Any word offset from 0x20 to 0x3C reads zero. Every read returns rresp OKAY (2'b00).
- R2: The instruction word at 0x00 keeps bit 31 (mode, 1 = GPIO), bit 23 (GPIO direction, 1 = release), bit 16 (GPIO level), bits 11:8 (opcode, driven on eng_opcode) and bits 7:0 (transmit byte, driven on eng_txbyte). All other bits read zero.
- R3: The control word at 0x04 keeps bit 31, which drives eng_srst, and bit 0, which drives eng_go. All other bits read zero.
- R4: The mask word at 0x08 keeps bit 4 (ready mask) and bit 0 (done mask). All other bits read zero.
- R5: On a write to the instruction, control or mask word, byte lane i (bits 8i+7:8i) is updated only when wstrb[i] is 1.
- R6: Writes to offsets 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x20 to 0x3C change nothing readable.
- R7: The status word at 0x0C shows eng_presence at bit 31, eng_ready at bit 4 and eng_done at bit 0. The word at 0x10 shows eng_rxbyte in bits 7:0. Both are captured on the clock edge after the engine drives them.
- R8: irq equals (captured ready AND mask bit 4) OR (captured done AND mask bit 0). It is therefore high one clock after the engine flag rises.
- R9: Write address and write data are accepted in either order. bvalid with bresp OKAY rises only after both have been accepted. bvalid stays high until bready. No new address or data is accepted while bvalid is high.
- R10: Once rvalid is high, it and rdata stay unchanged until rready.
- R11: In engine mode (bit 31 = 0), bus_oe follows eng_pull_low and bus_out is 0. In GPIO mode, direction 0 gives bus_oe = 1 with bus_out = the level bit. Direction 1 gives bus_oe = 0.
- R12: bit 0 of the word at 0x14 and eng_bus_level equal bus_in as it was two clock edges earlier, in either mode.

## Ports
| Port | Direction | Width | Description |
|--|--|--|--|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| eng_opcode | output | 4 | Opcode to the timing engine |
| eng_txbyte | output | 8 | Transmit byte to the engine |
| eng_go | output | 1 | Start request to the engine |
| eng_srst | output | 1 | Soft reset of the engine |
| eng_ready | input | 1 | Engine ready flag |
| eng_done | input | 1 | Engine done flag |
| eng_presence | input | 1 | Engine presence result |
| eng_rxbyte | input | 8 | Engine received byte |
| eng_pull_low | input | 1 | Engine request to pull the bus low |
| eng_bus_level | output | 1 | Synchronised bus level for the engine |
| bus_in | input | 1 | Raw bus pin level |
| bus_oe | output | 1 | Bus pin driver enable |
| bus_out | output | 1 | Level driven when bus_oe is high |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench sends write address and data together, address first with a gap, and data first with a gap. A design that answered after only one channel would raise bvalid during the gap. It sweeps all sixteen strobe patterns over the instruction word. A design that ignored wstrb or kept unimplemented bits would read back the wrong lanes. It sweeps every mask and flag combination for the interrupt, which catches a swapped or missing mask bit. It sweeps every mode, direction, level and engine-pull combination on the pin, which catches a mux that listens to the wrong owner. It also times a bus edge through the synchroniser and writes to every read-only and unmapped word. A design with the wrong synchroniser depth would show the edge one clock early or late. A design that decoded too loosely would corrupt the status, data or identity words.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam int DATA_W      = 32;
  localparam int STRB_W      = DATA_W / 8;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_WORDS   = 8;

  localparam logic [2:0] IDX_INSTR = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_MASK  = 3'd2;
  localparam logic [2:0] IDX_STAT  = 3'd3;
  localparam logic [2:0] IDX_RX    = 3'd4;
  localparam logic [2:0] IDX_GPIO  = 3'd5;
  localparam logic [2:0] IDX_VER   = 3'd6;
  localparam logic [2:0] IDX_ID    = 3'd7;

  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h7600_0100;
  localparam logic [DATA_W-1:0] IDENT_WORD   = 32'h10EE_4453;

  // implemented bits of the writable words
  localparam logic [DATA_W-1:0] INSTR_BITS = 32'h8081_0FFF;
  localparam logic [DATA_W-1:0] CTRL_BITS  = 32'h8000_0001;
  localparam logic [DATA_W-1:0] MASK_BITS  = 32'h0000_0011;

  localparam int BIT_MODE  = 31;
  localparam int BIT_DIR   = 23;
  localparam int BIT_LVL   = 16;
  localparam int BIT_SRST  = 31;
  localparam int BIT_GO    = 0;
  localparam int BIT_RDY   = 4;
  localparam int BIT_DONE  = 0;
  localparam int BIT_PRES  = 31;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [STRB_W-1:0] strb,
    input logic [DATA_W-1:0] keep
  );
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < STRB_W; i++) begin
      if (strb[i]) res[8*i +: 8] = new_w[8*i +: 8];
    end
    return res & keep;
  endfunction
endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owb_pinmux.sv
module owb_pinmux (
  input  logic gpio_mode,
  input  logic gpio_dir,
  input  logic gpio_lvl,
  input  logic eng_pull_low,
  output logic bus_oe,
  output logic bus_out
);
  always_comb begin
    if (gpio_mode) begin
      bus_oe  = ~gpio_dir;
      bus_out = gpio_lvl;
    end else begin
      bus_oe  = eng_pull_low;
      bus_out = 1'b0;
    end
  end
endmodule

// File: rtl/owb_axil_slave.sv
module owb_axil_slave
  import owb_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data
);
  logic              aw_full_q, aw_full_d;
  logic              w_full_q, w_full_d;
  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [IDX_W-1:0]  awidx_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [STRB_W-1:0] wstrb_q;
  logic              aw_hs, w_hs, ar_hs;
  logic              unused_lsb;

  assign unused_lsb = &{1'b0, awaddr[1:0], araddr[1:0]};

  assign awready = ~aw_full_q & ~bvalid_q;
  assign wready  = ~w_full_q & ~bvalid_q;
  assign arready = ~rvalid_q;
  assign aw_hs   = awvalid & awready;
  assign w_hs    = wvalid & wready;
  assign ar_hs   = arvalid & arready;
  assign wr_en   = aw_full_q & w_full_q;

  always_comb begin
    aw_full_d = aw_full_q;
    w_full_d  = w_full_q;
    bvalid_d  = bvalid_q;
    rvalid_d  = rvalid_q;
    if (aw_hs) aw_full_d = 1'b1;
    if (w_hs)  w_full_d  = 1'b1;
    if (wr_en) begin
      aw_full_d = 1'b0;
      w_full_d  = 1'b0;
      bvalid_d  = 1'b1;
    end else if (bvalid_q && bready) begin
      bvalid_d = 1'b0;
    end
    if (ar_hs)                  rvalid_d = 1'b1;
    else if (rvalid_q && rready) rvalid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      rvalid_q  <= 1'b0;
      awidx_q   <= '0;
      wdata_q   <= '0;
      wstrb_q   <= '0;
      rdata_q   <= '0;
    end else begin
      aw_full_q <= aw_full_d;
      w_full_q  <= w_full_d;
      bvalid_q  <= bvalid_d;
      rvalid_q  <= rvalid_d;
      if (aw_hs) awidx_q <= awaddr[ADDR_W-1:2];
      if (w_hs) begin
        wdata_q <= wdata;
        wstrb_q <= wstrb;
      end
      if (ar_hs) rdata_q <= rd_data;
    end
  end

  assign wr_idx  = awidx_q;
  assign wr_data = wdata_q;
  assign wr_strb = wstrb_q;
  assign rd_idx  = araddr[ADDR_W-1:2];
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;
endmodule

// File: rtl/owb_regbank.sv
module owb_regbank
  import owb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [3:0]        eng_opcode,
  output logic [7:0]        eng_txbyte,
  output logic              eng_go,
  output logic              eng_srst,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic              eng_presence,
  input  logic [7:0]        eng_rxbyte,
  input  logic              eng_pull_low,
  output logic              eng_bus_level,
  input  logic              bus_in,
  output logic              bus_oe,
  output logic              bus_out,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic              rst_sync_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  logic              wr_map, rd_map;

  logic [DATA_W-1:0] instr_q, instr_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              st_rdy_q, st_done_q, st_pres_q;
  logic [7:0]        rx_q;
  logic              bus_sync;

  // asynchronous assert, synchronous release
  owb_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  owb_axil_slave #(.ADDR_W(ADDR_W)) u_axil (
    .clk(clk), .rst_n(rst_sync_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign wr_map = 32'(wr_idx) < NUM_WORDS;
  assign rd_map = 32'(rd_idx) < NUM_WORDS;

  // register next state
  always_comb begin
    instr_d = instr_q;
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    if (wr_en && wr_map) begin
      case (wr_idx[2:0])
        IDX_INSTR: instr_d = lane_merge(instr_q, wr_data, wr_strb, INSTR_BITS);
        IDX_CTRL:  ctrl_d  = lane_merge(ctrl_q,  wr_data, wr_strb, CTRL_BITS);
        IDX_MASK:  mask_d  = lane_merge(mask_q,  wr_data, wr_strb, MASK_BITS);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      instr_q   <= '0;
      ctrl_q    <= '0;
      mask_q    <= '0;
      st_rdy_q  <= 1'b0;
      st_done_q <= 1'b0;
      st_pres_q <= 1'b0;
      rx_q      <= '0;
    end else begin
      instr_q   <= instr_d;
      ctrl_q    <= ctrl_d;
      mask_q    <= mask_d;
      st_rdy_q  <= eng_ready;
      st_done_q <= eng_done;
      st_pres_q <= eng_presence;
      rx_q      <= eng_rxbyte;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_map) begin
      case (rd_idx[2:0])
        IDX_INSTR: rd_data = instr_q;
        IDX_CTRL:  rd_data = ctrl_q;
        IDX_MASK:  rd_data = mask_q;
        IDX_STAT: begin
          rd_data[BIT_PRES] = st_pres_q;
          rd_data[BIT_RDY]  = st_rdy_q;
          rd_data[BIT_DONE] = st_done_q;
        end
        IDX_RX:    rd_data[7:0] = rx_q;
        IDX_GPIO:  rd_data[0]   = bus_sync;
        IDX_VER:   rd_data = VERSION_WORD;
        IDX_ID:    rd_data = IDENT_WORD;
        default: ;
      endcase
    end
  end

  owb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(bus_in), .q(bus_sync)
  );

  owb_pinmux u_pinmux (
    .gpio_mode(instr_q[BIT_MODE]), .gpio_dir(instr_q[BIT_DIR]),
    .gpio_lvl(instr_q[BIT_LVL]), .eng_pull_low(eng_pull_low),
    .bus_oe(bus_oe), .bus_out(bus_out)
  );

  assign eng_opcode    = instr_q[11:8];
  assign eng_txbyte    = instr_q[7:0];
  assign eng_go        = ctrl_q[BIT_GO];
  assign eng_srst      = ctrl_q[BIT_SRST];
  assign eng_bus_level = bus_sync;
  assign irq = (st_rdy_q & mask_q[BIT_RDY]) | (st_done_q & mask_q[BIT_DONE]);
endmodule

// File: rtl/owb_regbank_chk.sv
module owb_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awready,
  input logic        wready,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic        eng_ready,
  input logic        eng_done,
  input logic        irq,
  input logic        bus_in,
  input logic        eng_bus_level
);
  logic [1:0] live_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  // R9
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && bresp == 2'b00);
  // R9
  b_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready);
  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt != 2'd0 && !$past(eng_ready) && !$past(eng_done)) |-> !irq);
  // R12
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt == 2'd3 |-> eng_bus_level == $past(bus_in, owb_pkg::SYNC_STAGES));
endmodule

bind owb_regbank owb_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .awready(awready), .wready(wready),
  .bvalid(bvalid), .bready(bready), .bresp(bresp), .rvalid(rvalid),
  .rready(rready), .rdata(rdata), .eng_ready(eng_ready), .eng_done(eng_done),
  .irq(irq), .bus_in(bus_in), .eng_bus_level(eng_bus_level)
);

// File: tb/owb_regbank_tb.sv
`timescale 1ns/1ps
module owb_regbank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [3:0] eng_opcode;
  logic [7:0] eng_txbyte;
  logic eng_go, eng_srst, eng_bus_level, bus_oe, bus_out, irq;
  logic eng_ready = 0, eng_done = 0, eng_presence = 0, eng_pull_low = 0, bus_in = 0;
  logic [7:0] eng_rxbyte = '0;

  int n_tests = 0, n_fail = 0;
  logic b_early;
  logic [1:0] last_bresp;

  localparam logic [31:0] K_INSTR = 32'h8081_0FFF;

  always #5 clk = ~clk;

  owb_regbank #(.ADDR_W(6)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axw(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    logic aw_done = 0, w_done = 0, aw_hit, w_hit;
    b_early = 0;
    @(negedge clk);
    if (order != 2) begin awvalid = 1; awaddr = a; end
    if (order != 1) begin wvalid = 1; wdata = d; wstrb = s; end
    while (!aw_done || !w_done) begin
      aw_hit = awvalid && awready;
      w_hit  = wvalid && wready;
      @(negedge clk);
      if (aw_hit) begin awvalid = 0; aw_done = 1; end
      if (w_hit)  begin wvalid = 0;  w_done = 1; end
      if (aw_done && !w_done && !wvalid) begin
        repeat (2) begin @(negedge clk); b_early |= bvalid; end
        wvalid = 1; wdata = d; wstrb = s;
      end
      if (w_done && !aw_done && !awvalid) begin
        repeat (2) begin @(negedge clk); b_early |= bvalid; end
        awvalid = 1; awaddr = a;
      end
    end
    bready = 1;
    while (!bvalid) @(negedge clk);
    last_bresp = bresp;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axr(input logic [5:0] a, input int hold, output logic [31:0] d);
    logic [31:0] first;
    @(negedge clk);
    arvalid = 1; araddr = a;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    first = rdata;
    repeat (hold) @(negedge clk);
    if (hold > 0) chk("R10 rdata held", {rvalid, rdata[30:0]}, {1'b1, first[30:0]});
    chk("R1 rresp", {30'd0, rresp}, 32'd0);
    d = rdata;
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, lm, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values and unmapped reads
    for (int i = 0; i < 16; i++) begin
      axr(6'(i * 4), 0, rd);
      exp = (i == 6) ? 32'h7600_0100 : (i == 7) ? 32'h10EE_4453 : 32'd0;
      chk("R1 reset/unmapped read", rd, exp);
    end

    // R9 write orderings
    for (int o = 0; o < 3; o++) begin
      axw(6'h08, 32'h0000_0011, 4'hF, o);
      chk("R9 no early bvalid", {31'd0, b_early}, 32'd0);
      chk("R9 bresp OKAY", {30'd0, last_bresp}, 32'd0);
      axr(6'h08, 0, rd);
      chk("R4 mask readback", rd, 32'h11);
      axw(6'h08, 32'h0, 4'hF, o);
    end

    // R2 R5 strobe sweep on instruction word
    for (int s = 0; s < 16; s++) begin
      axw(6'h00, 32'h0, 4'hF, 0);
      axw(6'h00, 32'hFFFF_FFFF, 4'(s), 0);
      lm = '0;
      for (int b = 0; b < 4; b++) if (s[b]) lm[8*b +: 8] = 8'hFF;
      axr(6'h00, (s == 5) ? 3 : 0, rd);
      chk("R5 strobe lanes", rd, lm & K_INSTR);
      chk("R2 opcode/txbyte out", {20'd0, eng_opcode, eng_txbyte}, lm & 32'h0FFF);
    end
    axw(6'h00, 32'h0000_0D5A, 4'hF, 0);
    chk("R2 fields", {20'd0, eng_opcode, eng_txbyte}, 32'h0000_0D5A);

    // R3 control
    axw(6'h04, 32'hFFFF_FFFF, 4'hF, 0);
    axr(6'h04, 0, rd);
    chk("R3 ctrl readback", rd, 32'h8000_0001);
    chk("R3 srst/go", {30'd0, eng_srst, eng_go}, 32'd3);
    axw(6'h04, 32'h0000_0001, 4'h1, 0);
    chk("R3 srst held by strobe", {30'd0, eng_srst, eng_go}, 32'd3);
    axw(6'h04, 32'h0, 4'hF, 0);
    chk("R3 cleared", {30'd0, eng_srst, eng_go}, 32'd0);

    // R7 status and rx capture
    @(negedge clk);
    eng_presence = 1; eng_ready = 1; eng_done = 0; eng_rxbyte = 8'hA7;
    @(negedge clk);
    axr(6'h0C, 0, rd);
    chk("R7 status", rd, 32'h8000_0010);
    axr(6'h10, 0, rd);
    chk("R7 rx byte", rd, 32'h0000_00A7);

    // R6 writes to read-only and unmapped words ignored
    bus_in = 1;
    for (int i = 3; i < 16; i++) axw(6'(i * 4), 32'hFFFF_FFFF, 4'hF, 0);
    for (int i = 3; i < 16; i++) begin
      axr(6'(i * 4), 0, rd);
      exp = (i == 3) ? 32'h8000_0010 : (i == 4) ? 32'hA7 : (i == 5) ? 32'h1 :
            (i == 6) ? 32'h7600_0100 : (i == 7) ? 32'h10EE_4453 : 32'd0;
      chk("R6 ignored write", rd, exp);
    end
    axr(6'h00, 0, rd);
    chk("R6 instr untouched", rd, 32'h0000_0D5A);

    // R8 interrupt sweep
    for (int m = 0; m < 4; m++) begin
      axw(6'h08, {27'd0, m[1], 3'd0, m[0]}, 4'h1, 0);
      for (int st = 0; st < 4; st++) begin
        @(negedge clk);
        eng_ready = st[1]; eng_done = st[0];
        @(negedge clk);
        chk("R8 irq", {31'd0, irq}, {31'd0, (st[1] & m[1]) | (st[0] & m[0])});
      end
    end

    // R11 pin mux sweep
    for (int v = 0; v < 16; v++) begin
      axw(6'h00, {v[3], 7'd0, v[2], 6'd0, v[1], 16'd0}, 4'hF, 0);
      @(negedge clk);
      eng_pull_low = v[0];
      @(negedge clk);
      exp = {30'd0, v[3] ? ~v[2] : v[0], v[3] ? v[1] : 1'b0};
      chk("R11 oe/out", {30'd0, bus_oe, bus_out}, exp);
    end

    // R12 synchroniser delay in both modes
    for (int md = 0; md < 2; md++) begin
      axw(6'h00, {md[0], 31'd0}, 4'h8, 0);
      for (int b = 0; b < 2; b++) begin
        @(negedge clk);
        bus_in = b[0];
        @(negedge clk);
        chk("R12 one edge: old level", {31'd0, eng_bus_level}, {31'd0, ~b[0]});
        @(negedge clk);
        chk("R12 two edges: new level", {31'd0, eng_bus_level}, {31'd0, b[0]});
        axr(6'h14, 0, rd);
        chk("R12 gpio data", rd, {31'd0, b[0]});
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule